// File: doc/BRIEF.md
# Continuous Fixed-Frame CRC Transmitter

This block turns a stream of payload bytes into an unbroken serial bit stream made of fixed frames. Each frame carries 76 payload bytes (608 bits), sent most significant bit first. A 32-bit CRC over those bits follows them. The line never rests between frames: the first payload bit of the next frame follows the last CRC bit directly. Upstream logic must therefore keep supplying frame payloads, filler frames included, for as long as the link is meant to stay up.

Bytes arrive over a valid/ready handshake. One byte is held ahead in a prefetch register, so the next byte, or the first byte of the next frame, is ready at the moment it is needed. If that byte is missing, the block flags an underrun and holds the line high. It stays there until a restart command arrives.

The control machine has five states. STOP is the reset state. LOAD waits for the first byte of a new frame. DATA shifts out payload bits and CRC shifts out the checksum. UNDER is the state entered when a needed byte is missing. The transitions are:
- restart: STOP or UNDER to LOAD.
- load: LOAD to DATA, once a byte is held.
- next byte: DATA to DATA.
- payload end: DATA to CRC, after the last payload bit.
- frame wrap: CRC to DATA, after the last CRC bit, when a byte is held.
- starve: DATA or CRC to UNDER, when a byte is needed but not held.
- abort: any state to STOP, on a stop command.

Top module: `frame_crc_tx`

## Requirements
- R1: During and after reset the block is in STOP: tx_bit is 1, tx_active is 0, underrun is 0 and s_ready is 0.
- R2: A frame is 76 payload bytes, each sent bit 7 first. These are followed by a 32-bit CRC, sent bit 31 first. The CRC uses polynomial 0x04C11DB7, starts from all ones, processes the bits in transmission order, and is inverted before it is sent.
- R3: When the first byte of the next frame is held, that frame's first payload bit appears in the cycle right after the last CRC bit, with no idle bit between frames.
- R4: A restart sampled at edge k in STOP or UNDER enters LOAD, and tx_active goes high after edge k. If a byte is offered at edge k+1, the first payload bit of a new frame is on tx_bit after edge k+2.
- R5: A stop sampled at an edge aborts the current frame at once. After that edge tx_bit is 1, tx_active is 0, s_ready is 0, and any prefetched byte is discarded.
- R6: When stop and restart arrive in the same cycle, stop wins and the block ends in STOP.
- R7: A restart while in LOAD, DATA or CRC has no effect on the bit stream.
- R8: If a byte is needed, at a byte boundary inside a frame or at the end of a CRC, and none is held, the block enters UNDER. After that edge underrun is 1, tx_bit is 1, tx_active is 0 and s_ready is 0. A restart clears underrun.
- R9: s_ready is high only in LOAD, DATA or CRC while the prefetch register is empty. Each accepted handshake consumes exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 8 | Payload byte from upstream |
| s_valid | input | 1 | s_data holds a byte |
| s_ready | output | 1 | Block takes s_data at this edge if s_valid is high |
| cmd_stop | input | 1 | Abort the frame and enter STOP |
| cmd_restart | input | 1 | Leave STOP or UNDER and begin a new frame |
| tx_bit | output | 1 | Serial line; 1 when nothing is being sent |
| tx_active | output | 1 | High in LOAD, DATA and CRC |
| underrun | output | 1 | High in UNDER |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a stop and a restart pulsed together. The bench raises both for one cycle during a running frame and again while stopped, and expects tx_active to stay low on the following cycles. The second pair is a restart together with active shifting. The bench pulses restart in the middle of a frame and expects every bit of that frame and the next to keep matching the model. Frame payloads come from a seeded $urandom, and the stop point inside a frame is also drawn at random.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
    typedef enum logic [2:0] {
        S_STOP  = 3'd0,
        S_LOAD  = 3'd1,
        S_DATA  = 3'd2,
        S_CRC   = 3'd3,
        S_UNDER = 3'd4
    } ftx_state_e;

    localparam logic [31:0] FTX_POLY32 = 32'h04C11DB7;
endpackage

// File: rtl/ftx_crc_unit.sv
module ftx_crc_unit #(
    parameter int              CRC_W = 32,
    parameter logic [CRC_W-1:0] POLY = ftx_pkg::FTX_POLY32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic feed,
    input  logic shift,
    input  logic din,
    output logic crc_out
);
    logic [CRC_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            acc <= '1;
        end else if (feed) begin
            acc <= {acc[CRC_W-2:0], 1'b0} ^ ((acc[CRC_W-1] ^ din) ? POLY : '0);
        end else if (shift) begin
            acc <= {acc[CRC_W-2:0], 1'b0};
        end
    end

    // inverted remainder leaves MSB first
    assign crc_out = ~acc[CRC_W-1];
endmodule

// File: rtl/ftx_byte_buf.sv
module ftx_byte_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         enable,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         take,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic         held;
    logic [W-1:0] hold_q;

    assign in_ready  = enable && !held;
    assign out_valid = held;
    assign out_data  = hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            held <= 1'b0;
        end else if (in_valid && in_ready) begin
            held <= 1'b1;
        end else if (take) begin
            held <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (in_valid && in_ready) begin
            hold_q <= in_data;
        end
    end
endmodule

// File: rtl/frame_crc_tx.sv
module frame_crc_tx
    import ftx_pkg::*;
#(
    parameter int PAYLOAD_BYTES = 76,
    parameter int BYTE_W        = 8,
    parameter int CRC_W         = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic              cmd_stop,
    input  logic              cmd_restart,
    output logic              tx_bit,
    output logic              tx_active,
    output logic              underrun
);
    localparam int BIT_CW  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam int BYTE_CW = (PAYLOAD_BYTES > 1) ? $clog2(PAYLOAD_BYTES) : 1;
    localparam int CRC_CW  = $clog2(CRC_W);
    localparam logic [BIT_CW-1:0]  BIT_LAST  = BIT_CW'(BYTE_W - 1);
    localparam logic [BYTE_CW-1:0] BYTE_LAST = BYTE_CW'(PAYLOAD_BYTES - 1);
    localparam logic [CRC_CW-1:0]  CRC_LAST  = CRC_CW'(CRC_W - 1);

    ftx_state_e state, nxt;

    logic [BYTE_W-1:0]  cur_byte;
    logic [BIT_CW-1:0]  bit_cnt;
    logic [BYTE_CW-1:0] byte_cnt;
    logic [CRC_CW-1:0]  crc_cnt;

    logic              buf_en, buf_vld, take;
    logic [BYTE_W-1:0] buf_data;
    logic              crc_init, crc_bit;
    logic              last_bit, last_byte, last_crc;

    assign last_bit  = (bit_cnt == BIT_LAST);
    assign last_byte = (byte_cnt == BYTE_LAST);
    assign last_crc  = (crc_cnt == CRC_LAST);

    ftx_byte_buf #(.W(BYTE_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (cmd_stop),
        .enable   (buf_en),
        .in_valid (s_valid),
        .in_data  (s_data),
        .in_ready (s_ready),
        .take     (take),
        .out_valid(buf_vld),
        .out_data (buf_data)
    );

    assign crc_init = !(state == S_DATA || state == S_CRC) || (state == S_CRC && last_crc);

    ftx_crc_unit #(.CRC_W(CRC_W)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (crc_init),
        .feed   (state == S_DATA),
        .shift  (state == S_CRC),
        .din    (cur_byte[BYTE_W-1]),
        .crc_out(crc_bit)
    );

    // next-state and byte-take decision
    always_comb begin
        nxt  = state;
        take = 1'b0;
        if (cmd_stop) begin
            nxt = S_STOP;
        end else begin
            unique case (state)
                S_STOP, S_UNDER: begin
                    if (cmd_restart) nxt = S_LOAD;
                end
                S_LOAD: begin
                    if (buf_vld) begin
                        nxt  = S_DATA;
                        take = 1'b1;
                    end
                end
                S_DATA: begin
                    if (last_bit) begin
                        if (last_byte)    nxt = S_CRC;
                        else if (buf_vld) take = 1'b1;
                        else              nxt = S_UNDER;
                    end
                end
                S_CRC: begin
                    if (last_crc) begin
                        if (buf_vld) begin
                            nxt  = S_DATA;
                            take = 1'b1;
                        end else begin
                            nxt = S_UNDER;
                        end
                    end
                end
                default: nxt = S_STOP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_STOP;
        else        state <= nxt;
    end

    // shift register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_byte <= '0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            crc_cnt  <= '0;
        end else begin
            if (take) begin
                cur_byte <= buf_data;
                bit_cnt  <= '0;
                byte_cnt <= (state == S_DATA) ? byte_cnt + 1'b1 : '0;
            end else if (state == S_DATA) begin
                cur_byte <= {cur_byte[BYTE_W-2:0], 1'b0};
                bit_cnt  <= bit_cnt + 1'b1;
            end
            crc_cnt <= (state == S_CRC) ? crc_cnt + 1'b1 : '0;
        end
    end

    // outputs
    always_comb begin
        tx_bit    = 1'b1;
        tx_active = 1'b0;
        underrun  = 1'b0;
        buf_en    = 1'b0;
        unique case (state)
            S_LOAD: begin
                tx_active = 1'b1;
                buf_en    = 1'b1;
            end
            S_DATA: begin
                tx_bit    = cur_byte[BYTE_W-1];
                tx_active = 1'b1;
                buf_en    = 1'b1;
            end
            S_CRC: begin
                tx_bit    = crc_bit;
                tx_active = 1'b1;
                buf_en    = 1'b1;
            end
            S_UNDER: underrun = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/frame_crc_tx_chk.sv
module frame_crc_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic s_ready,
    input logic cmd_stop,
    input logic cmd_restart,
    input logic tx_bit,
    input logic tx_active,
    input logic underrun
);
    // R5
    stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> (!tx_active && tx_bit && !s_ready));

    // R6
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && cmd_restart) |=> !tx_active);

    // R8
    under_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (tx_bit && !tx_active && !s_ready));

    // R8
    under_from_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(tx_active));

    // R8
    under_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && cmd_restart && !cmd_stop) |=> (!underrun && tx_active));

    // R9
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> tx_active);
endmodule

bind frame_crc_tx frame_crc_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_ready    (s_ready),
    .cmd_stop   (cmd_stop),
    .cmd_restart(cmd_restart),
    .tx_bit     (tx_bit),
    .tx_active  (tx_active),
    .underrun   (underrun)
);

// File: tb/frame_crc_tx_bench.sv
module frame_crc_tx_bench;
    localparam int NB = 76;
    localparam int FB = 640;
    localparam int SZ = 8 * NB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] s_data;
    logic s_valid, s_ready;
    logic cmd_stop = 1'b0, cmd_restart = 1'b0;
    logic tx_bit, tx_active, underrun;

    logic [7:0] stream [SZ];
    int src_idx = 0, src_lim = 0;
    bit src_on = 1'b0;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    frame_crc_tx u_frame_crc_tx (
        .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .cmd_stop(cmd_stop), .cmd_restart(cmd_restart),
        .tx_bit(tx_bit), .tx_active(tx_active), .underrun(underrun)
    );

    function automatic logic [31:0] ref_crc(int base);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int b = 0; b < NB; b++) begin
            for (int k = 7; k >= 0; k--) begin
                logic fb = c[31] ^ stream[base + b][k];
                c = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C11DB7;
            end
        end
        return ~c;
    endfunction

    function automatic logic exp_bit(int base, int i);
        int fbase = base + (i / FB) * NB;
        int w = i % FB;
        logic [31:0] c;
        if (w < NB * 8) return stream[fbase + w / 8][7 - (w % 8)];
        c = ref_crc(fbase);
        return c[31 - (w - NB * 8)];
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // byte source: sample handshake mid-cycle, advance just after the edge
    initial begin
        s_valid = 1'b0;
        s_data  = 8'h00;
        forever begin
            bit fire;
            @(negedge clk);
            fire = s_valid && s_ready;
            @(posedge clk);
            #1;
            if (fire) src_idx++;
            s_valid = src_on && (src_idx < src_lim);
            s_data  = (src_idx < SZ) ? stream[src_idx] : 8'h00;
        end
    end

    task automatic pulse_restart();
        @(negedge clk); cmd_restart = 1'b1;
        @(negedge clk); cmd_restart = 1'b0;
    endtask

    // sampled at the negedge of bit 0; returns at the negedge of the last bit
    task automatic sample_bits(int base, int nbits, int rs_at, string req);
        int bad = 0, idle = 0;
        for (int i = 0; i < nbits; i++) begin
            if (i > 0) @(negedge clk);
            cmd_restart = (i == rs_at);
            if (tx_bit !== exp_bit(base, i)) bad++;
            if (tx_active !== 1'b1) idle++;
        end
        cmd_restart = 1'b0;
        chk(bad == 0, req, bad, 0);
        chk(idle == 0, "R3 tx_active", idle, 0);
    endtask

    task automatic start_frames(int base, int lim);
        src_idx = base; src_lim = lim; src_on = 1'b1;
        pulse_restart();
        // R4 after the restart edge: LOAD with empty prefetch
        chk(tx_active === 1'b1 && underrun === 1'b0, "R4 enter load", tx_active, 1);
        chk(s_ready === 1'b1, "R9 ready in load", s_ready, 1);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < SZ; i++) stream[i] = 8'($urandom);
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(tx_bit === 1'b1, "R1 tx_bit", tx_bit, 1);
        chk(tx_active === 1'b0, "R1 tx_active", tx_active, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(underrun === 1'b0, "R1 underrun", underrun, 0);
        chk(s_ready === 1'b0, "R1 s_ready", s_ready, 0);

        // R2 R3 R7: three frames back to back, restart pulsed mid-frame
        start_frames(0, 3 * NB);
        sample_bits(0, 3 * FB, FB + 300, "R2 R3 R7 frames");
        @(negedge clk);
        // R8 starved at frame end
        chk(underrun === 1'b1 && tx_bit === 1'b1, "R8 end underrun", underrun, 1);
        chk(tx_active === 1'b0 && s_ready === 1'b0, "R8 end quiet", tx_active, 0);

        // R8 restart from UNDER, then starved inside frame two
        start_frames(3 * NB, 4 * NB + 10);
        sample_bits(3 * NB, FB + 80, -1, "R4 R2 after underrun");
        @(negedge clk);
        chk(underrun === 1'b1 && tx_bit === 1'b1, "R8 mid underrun", underrun, 1);

        // R5 stop at a random point
        begin
            int k = 50 + int'($urandom % 550);
            start_frames(5 * NB, 7 * NB);
            sample_bits(5 * NB, k, -1, "R2 before stop");
            cmd_stop = 1'b1;
            @(negedge clk);
            cmd_stop = 1'b0;
            chk(tx_bit === 1'b1 && tx_active === 1'b0, "R5 abort", tx_active, 0);
            chk(s_ready === 1'b0 && underrun === 1'b0, "R5 ready low", s_ready, 0);
            repeat (5) @(negedge clk);
            chk(tx_bit === 1'b1 && tx_active === 1'b0, "R5 stays stopped", tx_bit, 1);
        end

        // R4 restart after stop begins a fresh frame
        start_frames(7 * NB, 8 * NB);
        sample_bits(7 * NB, FB, -1, "R4 fresh frame");

        // R6 stop and restart together, while active then while stopped
        start_frames(0, NB);
        sample_bits(0, 20, -1, "R2 before collision");
        cmd_stop = 1'b1; cmd_restart = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0; cmd_restart = 1'b0;
        chk(tx_active === 1'b0, "R6 active collide", tx_active, 0);
        @(negedge clk);
        chk(tx_active === 1'b0 && tx_bit === 1'b1, "R6 stays stopped", tx_active, 0);
        cmd_stop = 1'b1; cmd_restart = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0; cmd_restart = 1'b0;
        @(negedge clk);
        chk(tx_active === 1'b0 && s_ready === 1'b0, "R6 stopped collide", tx_active, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule